// File: doc/BRIEF.md
# Z80 Bus Banked ROM Emulator

This block stands in for the 16 KB read-only memory at the bottom of a Z80 address map. A system clock of 50 MHz or more samples the CPU bus through a two-stage synchroniser. The block recognises memory cycles aimed at the lower 16 KB. On a read it puts the addressed byte of the active image onto the data bus and raises the enable of the external bus driver. Outside such a read that enable stays low, so the bus is left free for other devices. The CPU never inserts wait states, so every read has to meet the opcode-fetch deadline of about 430 ns.

Software selects the active image by writing a byte anywhere in the ROM region. The byte is taken as the new bank number when the write strobe returns high. A number beyond the implemented banks is discarded. A bank change is also held back until any read in progress has ended. Image contents are computed from a parameter seed, so no storage is built.

The block keeps the line that disables the machine's own ROM in its disabling state. It also holds the CPU reset low for a set time after the block's own reset, and whenever the reset button is pressed.

Top module: `z80_rom_emu`

## Requirements
- R1: A read is recognised only when address bits 15 and 14, `mreq_n_i` and `rd_n_i` are all low at the same time. `data_oe_o` is high only for such a read.
- R2: Whenever any one of those four signals is high, `data_oe_o` is low, which means the data bus is released.
- R3: `data_oe_o` and `data_o` respond on the third rising clock edge after the bus inputs change. This is within the 8 system-clock budget and well inside 430 ns at 250 MHz.
- R4: The byte read from address `a` (bits 13:0) of bank `b` is `((a[7:0] + a[13:8]) mod 256) XOR ((b*71 + SEED) mod 256)`, with SEED = 0xA5 by default.
- R5: `rom_dis_o` is 1 at all times, including during reset.
- R6: A write to the ROM region latches `data_i` as the next bank number. The change takes effect after `wr_n_i` rises. A write with address bit 14 or 15 high is ignored.
- R7: A written bank number of NUM_BANKS (default 4) or more is ignored, and the current bank is kept.
- R8: After `rst_n` is released, `cpu_rst_n_o` stays low for POR_CYCLES clocks (default 16) and then goes high.
- R9: While `btn_n_i` is low, `cpu_rst_n_o` is low. It follows the button with a latency of three clocks.
- R10: After reset, bank 0 is active.
- R11: A bank change never alters the data driven during an ongoing read. It is applied once that read has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz or faster |
| rst_n | input | 1 | Synchronous active-low block reset |
| addr_i | input | 16 | CPU address bus |
| data_i | input | 8 | CPU data bus as seen on writes |
| mreq_n_i | input | 1 | Active-low memory request |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| btn_n_i | input | 1 | Active-low reset button |
| data_o | output | 8 | Byte to drive onto the data bus |
| data_oe_o | output | 1 | Enable for the external data driver |
| rom_dis_o | output | 1 | Disables the machine's own ROM, always high |
| cpu_rst_n_o | output | 1 | Active-low CPU reset |

## Verification
The bench sweeps all sixteen combinations of the two high address bits and the request and read strobes. A decoder that used OR in place of AND would drive the bus during RAM or I/O cycles. The bench samples the output one edge early and on the exact edge, so an extra or a missing pipeline stage is caught. Bank numbers just past the limit, far past it, and written outside the region are all checked. Any of these would otherwise switch to a phantom image. The bench also writes during a held read, so a bank register that committed at once would change the byte while the CPU was still sampling it.

// File: rtl/z80_rom_emu_pkg.sv
// Shared types and the image-content function for the ROM emulator.
// Assumes a 16-bit Z80 address bus and an 8-bit data bus.
package z80_rom_emu_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int OFFS_W = 14;

    // One snapshot of every bus input that crosses into the system clock.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              mreq_n;
        logic              rd_n;
        logic              wr_n;
        logic              btn_n;
    } bus_sample_t;

    localparam int SAMPLE_W = $bits(bus_sample_t);

    // Computed image byte: stands in for a loaded image, with no storage.
    function automatic logic [DATA_W-1:0] image_byte(
        input logic [DATA_W-1:0] bank,
        input logic [OFFS_W-1:0] offs,
        input logic [DATA_W-1:0] seed
    );
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] key;
        lo  = offs[7:0];
        hi  = {2'b00, offs[13:8]};
        key = 8'(bank * 8'h47) + seed;
        return 8'(lo + hi) ^ key;
    endfunction

endpackage

// File: rtl/bus_sync.sv
// Two-stage synchroniser for a vector of asynchronous bus inputs.
// Assumes the bus changes slowly against clk, so each bit settles on its own.
module bus_sync #(
    parameter int              WIDTH   = 8,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/bank_ctrl.sv
// Holds the active bank. A ROM-region write arms a pending value; once the
// write strobe is high again and no read is running, a valid value commits.
// Assumes all inputs are already synchronised to clk.
module bank_ctrl #(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit_i,
    input  logic              wr_n_i,
    input  logic              reading_i,
    input  logic [7:0]        wdata_i,
    output logic [BANK_W-1:0] bank_o
);

    logic [BANK_W-1:0] bank_q;
    logic [7:0]        pend_q;
    logic              armed_q;
    logic              commit;
    logic              in_range;

    assign in_range = (32'(pend_q) < NUM_BANKS);
    assign commit   = armed_q && wr_n_i && !reading_i;

    // Capture write data while the strobe is low; apply it after the strobe ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            pend_q  <= '0;
            armed_q <= 1'b0;
        end else if (wr_hit_i) begin
            pend_q  <= wdata_i;
            armed_q <= 1'b1;
        end else if (commit) begin
            armed_q <= 1'b0;
            if (in_range) begin
                bank_q <= BANK_W'(pend_q);
            end
        end
    end

    assign bank_o = bank_q;

    // R7: an out-of-range commit leaves the bank untouched.
    p_ignore_far_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !wr_hit_i && (32'(pend_q) >= NUM_BANKS)) |=> $stable(bank_q));

    // R11: no bank change lands while a read is under way.
    p_bank_frozen_in_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reading_i |=> $stable(bank_q));

endmodule

// File: rtl/rom_reader.sv
// Output stage: registers the image byte and the driver enable for a decoded read.
// Assumes the address and the hit flag come from the synchroniser.
module rom_reader #(
    parameter int         BANK_W = 2,
    parameter logic [7:0] SEED   = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_hit_i,
    input  logic [13:0]       offs_i,
    input  logic [BANK_W-1:0] bank_i,
    output logic [7:0]        data_o,
    output logic              oe_o
);
    import z80_rom_emu_pkg::*;

    logic [7:0] data_q;
    logic       oe_q;

    // Register the looked-up byte and the driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q   <= rd_hit_i;
            data_q <= rd_hit_i ? image_byte(8'(bank_i), offs_i, SEED) : 8'h00;
        end
    end

    assign data_o = data_q;
    assign oe_o   = oe_q;

endmodule

// File: rtl/reset_gen.sv
// CPU reset control: holds reset for POR_CYCLES after the block reset, and
// whenever the (synchronised) button input is low.
module reset_gen #(
    parameter int POR_CYCLES = 16,
    localparam int CNT_W     = $clog2(POR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n_i,
    output logic cpu_rst_n_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             ready;
    logic             cpu_rst_n_q;

    assign ready = (cnt_q == CNT_W'(POR_CYCLES));

    // Count up to the power-up hold time, then stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!ready) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Release the CPU only when ready and the button is not pressed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rst_n_q <= 1'b0;
        end else begin
            cpu_rst_n_q <= ready && btn_n_i;
        end
    end

    assign cpu_rst_n_o = cpu_rst_n_q;

    // R8: the CPU stays in reset until the hold time has passed.
    p_hold_until_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> !cpu_rst_n_o);

    // R9: a pressed button forces the CPU into reset.
    p_button_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_n_i |=> !cpu_rst_n_o);

endmodule

// File: rtl/z80_rom_emu.sv
// Top level: synchronises the Z80 bus, decodes lower-16K cycles, serves reads
// from the active bank and treats writes as bank-select commands.
// Assumes clk is at least 50 MHz, so 3 clocks of latency meet the 430 ns fetch limit.
module z80_rom_emu #(
    parameter int         NUM_BANKS  = 4,
    parameter int         POR_CYCLES = 16,
    parameter logic [7:0] SEED       = 8'hA5,
    localparam int        BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] addr_i,
    input  logic [7:0]  data_i,
    input  logic        mreq_n_i,
    input  logic        rd_n_i,
    input  logic        wr_n_i,
    input  logic        btn_n_i,
    output logic [7:0]  data_o,
    output logic        data_oe_o,
    output logic        rom_dis_o,
    output logic        cpu_rst_n_o
);
    import z80_rom_emu_pkg::*;

    localparam bus_sample_t IDLE = '{addr: '0, data: '0, mreq_n: 1'b1,
                                     rd_n: 1'b1, wr_n: 1'b1, btn_n: 1'b1};

    bus_sample_t        raw;
    bus_sample_t        smp;
    logic               region;
    logic               rd_hit;
    logic               wr_hit;
    logic [BANK_W-1:0]  bank;

    assign raw = '{addr: addr_i, data: data_i, mreq_n: mreq_n_i,
                   rd_n: rd_n_i, wr_n: wr_n_i, btn_n: btn_n_i};

    bus_sync #(.WIDTH(SAMPLE_W), .RST_VAL(IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (smp)
    );

    // Lower-16K memory cycle decode on the synchronised sample.
    assign region = !smp.mreq_n && !smp.addr[15] && !smp.addr[14];
    assign rd_hit = region && !smp.rd_n;
    assign wr_hit = region && !smp.wr_n;

    bank_ctrl #(.NUM_BANKS(NUM_BANKS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit_i  (wr_hit),
        .wr_n_i    (smp.wr_n),
        .reading_i (rd_hit || data_oe_o),
        .wdata_i   (smp.data),
        .bank_o    (bank)
    );

    rom_reader #(.BANK_W(BANK_W), .SEED(SEED)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hit_i (rd_hit),
        .offs_i   (smp.addr[13:0]),
        .bank_i   (bank),
        .data_o   (data_o),
        .oe_o     (data_oe_o)
    );

    reset_gen #(.POR_CYCLES(POR_CYCLES)) u_rst (
        .clk         (clk),
        .rst_n       (rst_n),
        .btn_n_i     (smp.btn_n),
        .cpu_rst_n_o (cpu_rst_n_o)
    );

    assign rom_dis_o = 1'b1;

    // R1/R2: the driver is enabled only after a full lower-16K read decode.
    p_drive_only_on_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> $past(!smp.mreq_n && !smp.rd_n && !smp.addr[15] && !smp.addr[14]));

endmodule

// File: tb/tb_z80_rom_emu.sv
`timescale 1ns/1ps
module tb_z80_rom_emu;

    localparam int NB  = 4;
    localparam int POR = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        mreq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        btn_n = 1'b1;
    logic [7:0]  data_o;
    logic        data_oe;
    logic        rom_dis;
    logic        cpu_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    z80_rom_emu #(.NUM_BANKS(NB), .POR_CYCLES(POR), .SEED(8'hA5)) dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .data_i(wdata),
        .mreq_n_i(mreq_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .btn_n_i(btn_n),
        .data_o(data_o), .data_oe_o(data_oe), .rom_dis_o(rom_dis),
        .cpu_rst_n_o(cpu_rst_n)
    );

    function automatic int expect_byte(input int bank, input int a);
        int lo = a % 256;
        int hi = (a / 256) % 64;
        return ((lo + hi) % 256) ^ ((bank * 71 + 165) % 256);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Full read with exact-edge latency checks (R3), then release.
    task automatic do_read(input int a, input int bank, input string tag);
        @(negedge clk);
        addr = 16'(a); mreq_n = 1'b0; rd_n = 1'b0;
        wait_neg(2);
        chk({tag, " R3 early oe"}, int'(data_oe), 0);
        wait_neg(1);
        chk({tag, " R3 oe"}, int'(data_oe), 1);
        chk({tag, " R4 data"}, int'(data_o), expect_byte(bank, a));
        mreq_n = 1'b1; rd_n = 1'b1;
        wait_neg(3);
        chk({tag, " R2 release"}, int'(data_oe), 0);
    endtask

    task automatic do_write(input int a, input int v);
        @(negedge clk);
        addr = 16'(a); wdata = 8'(v); mreq_n = 1'b0; wr_n = 1'b0;
        wait_neg(4);
        wr_n = 1'b1; mreq_n = 1'b1;
        wait_neg(5);
    endtask

    initial begin
        // Reset state
        wait_neg(3);
        chk("R2 reset oe", int'(data_oe), 0);
        chk("R5 reset rom_dis", int'(rom_dis), 1);
        chk("R8 reset cpu", int'(cpu_rst_n), 0);
        rst_n = 1'b1;
        wait_neg(POR - 2);
        chk("R8 still held", int'(cpu_rst_n), 0);
        wait_neg(5);
        chk("R8 released", int'(cpu_rst_n), 1);

        // Button
        btn_n = 1'b0;
        wait_neg(2);
        chk("R9 button early", int'(cpu_rst_n), 1);
        wait_neg(1);
        chk("R9 button held", int'(cpu_rst_n), 0);
        btn_n = 1'b1;
        wait_neg(3);
        chk("R9 button release", int'(cpu_rst_n), 1);

        // R10: bank 0 after reset, at both ends of the region
        do_read(0, 0, "R10 low");
        do_read(16383, 0, "R10 high");

        // R1/R2 decode sweep: {A15,A14,mreq_n,rd_n}
        for (int c = 0; c < 16; c++) begin
            int want;
            @(negedge clk);
            addr = {c[3], c[2], 14'h0123};
            mreq_n = c[1]; rd_n = c[0];
            wait_neg(3);
            want = (c == 0) ? 1 : 0;
            chk($sformatf("R1 decode %0d", c), int'(data_oe), want);
            if (want == 1) chk("R1 decode data", int'(data_o), expect_byte(0, 16'h0123));
            chk("R5 rom_dis", int'(rom_dis), 1);
            mreq_n = 1'b1; rd_n = 1'b1;
            wait_neg(3);
            chk("R2 idle", int'(data_oe), 0);
        end

        // R6: select bank 2
        do_write(16'h0000, 2);
        do_read(16'h0100, 2, "R6 bank2");
        // R6: write outside the region is ignored
        do_write(16'h4000, 1);
        do_read(16'h0100, 2, "R6 outside");
        do_write(16'h8000, 3);
        do_read(16'h0200, 2, "R6 outside hi");
        // R7: out-of-range numbers ignored
        do_write(16'h1234, NB);
        do_read(16'h0055, 2, "R7 limit");
        do_write(16'h3FFF, 200);
        do_read(16'h0055, 2, "R7 far");

        // R11: a write during a held read is deferred
        @(negedge clk);
        addr = 16'h0777; mreq_n = 1'b0; rd_n = 1'b0;
        wait_neg(3);
        chk("R11 before", int'(data_o), expect_byte(2, 16'h0777));
        wdata = 8'd1; wr_n = 1'b0;
        wait_neg(4);
        wr_n = 1'b1;
        wait_neg(5);
        chk("R11 oe held", int'(data_oe), 1);
        chk("R11 data held", int'(data_o), expect_byte(2, 16'h0777));
        mreq_n = 1'b1; rd_n = 1'b1;
        wait_neg(4);
        do_read(16'h0777, 1, "R11 after");

        // R4 sweep over every bank
        for (int b = 0; b < NB; b++) begin
            do_write(16'h2000 + b, b);
            for (int k = 0; k < 64; k++) begin
                do_read((k * 257 + b * 13) % 16384, b, $sformatf("R4 b%0d", b));
            end
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule